// File: doc/BRIEF.md
# Key-Return Falling-Edge Wake Detector

This block watches an eight-line key port and reports key presses. A mode register chooses which port lines are watched. The four low lines share one enable bit, and each of the four high lines has an enable bit of its own. Every port line passes through a two-flop synchronizer. When a watched line goes from high to low, the block raises a sticky interrupt request flag and drives a one-cycle standby-release pulse toward the power and clock controller. The mask bit decides only whether the flag reaches the interrupt request output. The wake pulse does not depend on the mask.

Software reaches the block over a small register bus that has an address, a write strobe, write data and combinational read data. The mode register sits at `MODE_ADDR`, default FFF5H. A control register at `CTL_ADDR`, default FFF6H, holds the flag in bit 0 and the mask in bit 1. For every watched line the block also drives a pull-up enable, unless that line is configured as an output.

Top module: `keyret_wake`

## Requirements
- R1: After reset the mode register reads 00H, the control register reads 02H (flag 0, mask 1), and every pull-up enable, `irq_req` and `wake_pulse` are 0.
- R2: Mode bits 1, 2 and 3 are reserved. A write stores 0 in them and they always read back 0. Bits 0 and 4 to 7 store the written value.
- R3: Mode bit 0 enables falling-edge detection on port lines 0 to 3 as one group.
- R4: Mode bit n, for n from 4 to 7, enables falling-edge detection on port line n only.
- R5: Only a high-to-low change on an enabled line is detected. Rising changes are ignored. Changes on lines that are not enabled are also ignored.
- R6: A falling change on an input appears as a one-cycle `wake_pulse` on the third rising clock edge after the change: two synchronizer stages, then the output register. Lines that fall together in the same cycle give a single pulse.
- R7: A detection sets the flag (control bit 0) at the same edge as the wake pulse. The flag stays set until software writes 0 to it. If that write and a new detection fall on the same edge, the flag stays set.
- R8: `irq_req` equals flag AND NOT mask (control bit 1). `wake_pulse` occurs whatever the mask value.
- R9: `pullup_en[n]` is 1 exactly when line n is enabled for detection by R3 or R4 and `pin_is_out[n]` is 0.
- R10: Reads from any address other than the two mapped ones return 0. Writes to such an address change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| port_in | input | 8 | Asynchronous key port lines |
| pin_is_out | input | 8 | 1 when the line is configured as an output |
| pullup_en | output | 8 | Per-line pull-up enable |
| irq_req | output | 1 | Interrupt request (flag and not mask) |
| wake_pulse | output | 1 | One-cycle standby-release pulse |

## Verification
The bench checks whether the low four lines follow mode bit 0 as one group while the high four lines each follow their own bit. A design that mapped these the wrong way would wake on the wrong keys. A write to the flag is placed on exactly the edge where a detection lands. If the clear won that race, the key press would be lost. Rising changes, changes on disabled lines, and simultaneous falls on several lines are all applied. These expose a detector that uses the wrong polarity, skips the enable, or gives more than one pulse for one press. The bench also checks that the wake pulse still fires while the mask is set, and that output lines lose their pull-up. A design that tied wake to the mask would leave the device asleep.

// File: rtl/keyret_pkg.sv
package keyret_pkg;
    localparam int PORT_W  = 8;
    localparam int GROUP_W = 4;
    localparam int DATA_W  = 8;

    localparam logic [DATA_W-1:0] MODE_KEEP = 8'hF1;

    typedef struct packed {
        logic [PORT_W-1:0] meta;
        logic [PORT_W-1:0] stable;
    } sync_st_t;

    typedef struct packed {
        logic [PORT_W-1:0] last;
        logic              wake;
    } edge_st_t;

    typedef struct packed {
        logic [PORT_W-1:0] mode;
        logic              flag;
        logic              mask;
    } reg_st_t;
endpackage

// File: rtl/keyret_sync.sv
module keyret_sync
    import keyret_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] raw_i,
    output logic [PORT_W-1:0] sync_o
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/keyret_edge.sv
module keyret_edge
    import keyret_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] samp_i,
    input  logic [PORT_W-1:0] mode_i,
    output logic [PORT_W-1:0] en_o,
    output logic              fall_any_o,
    output logic              wake_o
);
    edge_st_t st_d, st_q;
    logic [PORT_W-1:0] fall;

    // Low lines follow the shared group bit, high lines their own bit.
    for (genvar i = 0; i < PORT_W; i++) begin : g_en
        if (i < GROUP_W) begin : g_grp
            assign en_o[i] = mode_i[0];
        end else begin : g_ind
            assign en_o[i] = mode_i[i];
        end
    end

    always_comb begin
        fall       = st_q.last & ~samp_i & en_o;
        fall_any_o = |fall;
        st_d       = st_q;
        st_d.last  = samp_i;
        st_d.wake  = fall_any_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake_o = st_q.wake;
endmodule

// File: rtl/keyret_regs.sv
module keyret_regs
    import keyret_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFFF5,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 16'hFFF6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              fall_any_i,
    output logic [PORT_W-1:0] mode_o,
    output logic              irq_o
);
    reg_st_t st_d, st_q;
    logic    hit_mode, hit_ctl;

    always_comb begin
        hit_mode = (addr_i == MODE_ADDR);
        hit_ctl  = (addr_i == CTL_ADDR);
        st_d     = st_q;
        if (we_i && hit_mode) st_d.mode = wdata_i & MODE_KEEP;
        if (we_i && hit_ctl) begin
            st_d.flag = wdata_i[0];
            st_d.mask = wdata_i[1];
        end
        if (fall_any_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: '0, flag: 1'b0, mask: 1'b1};
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (hit_mode)     rdata_o = st_q.mode;
        else if (hit_ctl) rdata_o = {{(DATA_W-2){1'b0}}, st_q.mask, st_q.flag};
    end

    assign mode_o = st_q.mode;
    assign irq_o  = st_q.flag & ~st_q.mask;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_any_i |=> st_q.flag);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(we_i && hit_ctl)) |=> st_q.flag);
    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_any_i |=> (irq_o || st_q.mask));
endmodule

// File: rtl/keyret_wake.sv
module keyret_wake
    import keyret_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFFF5,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 16'hFFF6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] pin_is_out,
    output logic [PORT_W-1:0] pullup_en,
    output logic              irq_req,
    output logic              wake_pulse
);
    logic [PORT_W-1:0] samp, mode, en;
    logic              fall_any;

    keyret_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (port_in),
        .sync_o(samp)
    );

    keyret_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_i    (samp),
        .mode_i    (mode),
        .en_o      (en),
        .fall_any_o(fall_any),
        .wake_o    (wake_pulse)
    );

    keyret_regs #(
        .ADDR_W   (ADDR_W),
        .MODE_ADDR(MODE_ADDR),
        .CTL_ADDR (CTL_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .we_i      (bus_we),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .fall_any_i(fall_any),
        .mode_o    (mode),
        .irq_o     (irq_req)
    );

    for (genvar i = 0; i < PORT_W; i++) begin : g_pu
        assign pullup_en[i] = en[i] & ~pin_is_out[i];
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == MODE_ADDR) |-> (bus_rdata[3:1] == 3'b000));
    // R5
    wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(mode) != '0));
    // R9
    pullup_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_en != '0) |-> (mode != '0));
endmodule

// File: tb/sim_keyret_wake.sv
`timescale 1ns/1ps
module sim_keyret_wake;
    localparam logic [15:0] A_MODE = 16'hFFF5;
    localparam logic [15:0] A_CTL  = 16'hFFF6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  port_in = 8'hFF;
    logic [7:0]  pin_is_out = 8'h00;
    logic [7:0]  pullup_en;
    logic        irq_req, wake_pulse;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    keyret_wake u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_in(port_in),
        .pin_is_out(pin_is_out), .pullup_en(pullup_en), .irq_req(irq_req),
        .wake_pulse(wake_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] exp);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    // Change the port at a falling edge, then count wake pulses for n cycles.
    task automatic drive_count(input logic [7:0] val, input int n, output int pulses);
        @(negedge clk);
        port_in = val;
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wake_pulse) pulses++;
        end
    endtask

    task automatic t_reset;
        check("R1 wake", {7'b0, wake_pulse}, 8'h00);
        check("R1 irq", {7'b0, irq_req}, 8'h00);
        check("R1 pullup", pullup_en, 8'h00);
        rd_check("R1 mode", A_MODE, 8'h00);
        rd_check("R1 ctl", A_CTL, 8'h02);
    endtask

    task automatic t_reserved;
        wr(A_MODE, 8'hFF);
        rd_check("R2 reserved", A_MODE, 8'hF1);
        wr(A_MODE, 8'h0E);
        rd_check("R2 reserved only", A_MODE, 8'h00);
    endtask

    task automatic t_unmapped;
        wr(A_MODE, 8'h10);
        wr(16'h1234, 8'hAA);
        rd_check("R10 read", 16'h1234, 8'h00);
        rd_check("R10 mode kept", A_MODE, 8'h10);
        rd_check("R10 ctl kept", A_CTL, 8'h02);
    endtask

    task automatic t_latency;
        wr(A_MODE, 8'h01);
        @(negedge clk);
        port_in = 8'hFB;
        @(negedge clk); check("R6 cyc1", {7'b0, wake_pulse}, 8'h00);
        @(negedge clk); check("R6 cyc2", {7'b0, wake_pulse}, 8'h00);
        @(negedge clk); check("R6 cyc3", {7'b0, wake_pulse}, 8'h01);
        rd_check("R7 flag set", A_CTL, 8'h03);
        @(negedge clk); check("R6 one cycle", {7'b0, wake_pulse}, 8'h00);
        rd_check("R7 flag sticky", A_CTL, 8'h03);
    endtask

    task automatic t_rise_ignored;
        int p;
        drive_count(8'hFF, 6, p);
        check("R5 rising ignored", p[7:0], 8'd0);
        wr(A_CTL, 8'h02);
        rd_check("R7 clear", A_CTL, 8'h02);
    endtask

    task automatic t_group;
        int p;
        wr(A_MODE, 8'h01);
        drive_count(8'hF7, 6, p);
        check("R3 pin3", p[7:0], 8'd1);
        drive_count(8'hFF, 4, p);
        drive_count(8'hFE, 6, p);
        check("R3 pin0", p[7:0], 8'd1);
        drive_count(8'hFF, 4, p);
        drive_count(8'hEF, 6, p);
        check("R3 pin4 not in group", p[7:0], 8'd0);
        drive_count(8'hFF, 4, p);
    endtask

    task automatic t_individual;
        int p;
        wr(A_MODE, 8'h10);
        drive_count(8'hDF, 6, p);
        check("R5 disabled pin5", p[7:0], 8'd0);
        drive_count(8'hFF, 4, p);
        drive_count(8'hF0, 6, p);
        check("R4 low pins off", p[7:0], 8'd0);
        drive_count(8'hFF, 4, p);
        drive_count(8'hEF, 6, p);
        check("R4 pin4", p[7:0], 8'd1);
        drive_count(8'hFF, 4, p);
        wr(A_MODE, 8'hF0);
        drive_count(8'h2F, 6, p);
        check("R6 simultaneous one pulse", p[7:0], 8'd1);
        drive_count(8'hFF, 4, p);
    endtask

    task automatic t_mask;
        int p;
        wr(A_CTL, 8'h02);
        wr(A_MODE, 8'h80);
        drive_count(8'h7F, 6, p);
        check("R8 wake while masked", p[7:0], 8'd1);
        check("R8 irq masked", {7'b0, irq_req}, 8'h00);
        wr(A_CTL, 8'h01);
        check("R8 irq unmasked", {7'b0, irq_req}, 8'h01);
        wr(A_CTL, 8'h00);
        check("R8 irq cleared", {7'b0, irq_req}, 8'h00);
        drive_count(8'hFF, 4, p);
    endtask

    task automatic t_set_wins;
        wr(A_MODE, 8'h40);
        wr(A_CTL, 8'h00);
        @(negedge clk);
        port_in = 8'hBF;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_CTL; bus_wdata = 8'h00; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        check("R6 pulse at race", {7'b0, wake_pulse}, 8'h01);
        rd_check("R7 set wins", A_CTL, 8'h01);
        check("R8 irq after race", {7'b0, irq_req}, 8'h01);
        @(negedge clk);
        port_in = 8'hFF;
        wr(A_CTL, 8'h02);
    endtask

    task automatic t_pullup;
        wr(A_MODE, 8'h91);
        pin_is_out = 8'h82;
        #0.5;
        check("R9 mixed", pullup_en, 8'h1D);
        pin_is_out = 8'h00;
        #0.5;
        check("R9 all in", pullup_en, 8'h9F);
        wr(A_MODE, 8'h60);
        check("R9 individual", pullup_en, 8'h60);
        wr(A_MODE, 8'h00);
        check("R9 none", pullup_en, 8'h00);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        t_reserved;
        t_unmapped;
        t_latency;
        t_rise_ignored;
        t_group;
        t_individual;
        t_mask;
        t_set_wins;
        t_pullup;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule